// File: doc/BRIEF.md
# DMA Parallel Port Handshake Engine

This block moves a block of bytes between a DMA requester and an external parallel port device without the processor stepping in for each byte. In send mode it asks the DMA side for a byte, drives it onto the data pins and pulses the strobe line low until the far end answers with a low acknowledge level. A low busy level from the far end holds off the next request. In receive mode it waits for a falling acknowledge edge. It then pulses the line-feed control low while it latches the pin data, hands the byte to the DMA side, and drives strobe low until acknowledge returns high. A terminal-count input, sampled with each DMA acknowledge, marks the last byte of the block.

Software runs the engine through three byte-wide registers on a small synchronous bus: a command/enable register, a status register and a key register. Only a few command codes are accepted. The engine will not start a transfer until the key register holds 16h. Interrupt sources are latched in the status register and drive `irq`. All peripheral inputs are taken as already synchronized to `clk`. Each control output is low-active at the pin.

Top module: `ppdma_engine`

## Requirements
- R1: After the DMA side acknowledges a send request, from the next cycle `pd_out` carries the byte and `strobe_n` is low. Both hold until `ack_n` is seen low.
- R2: One cycle after `ack_n` is sampled low in send mode, `strobe_n` is high. A new `dma_req` follows once `ack_n` is high again. If the byte was flagged with `dma_tc`, the engine goes idle instead.
- R3: In send mode `dma_req` stays low while `busy_n` is low (or `ack_n` is low).
- R4: In receive mode a 1→0 change of `ack_n` makes `autofd_n` low for one cycle and releases the data pins (`pd_oe` low). The pin byte is then offered on `dma_rdata` with `dma_req` high. After the DMA acknowledge, `strobe_n` goes low until `ack_n` is high.
- R5: Command register (address 0) writes are decoded on bits {7,6,1,0}. 0001 only loads the interrupt enables. 0010 stops any transfer and clears the end-of-data flag. 0011 halts. 0101 arms receive. 1001 starts send. Bits 5..2 of an accepted write are the enables. A read returns the enables in bits 5..2 and the busy flag in bit 0.
- R6: A command write with any other bit-{7,6,1,0} value is ignored. The enables, the transfer and the status stay as they were.
- R7: With enable bit 5 set, status bit 5 is latched when a transfer completes. It is also latched on any `ack_n` change while the end-of-data flag is set.
- R8: Enable bits 4, 3 and 2 latch status bits 4, 3 and 2 on any change of `slct`, `err_n` and `pe` respectively. A change on a disabled line latches nothing.
- R9: Status (address 1) bit 6 is the end-of-data flag, set on terminal-count completion or a halt. Bits 7, 1 and 0 read as zero. `irq` is high whenever any of status bits 5..2 is set.
- R10: A start (1001) or arm (0101) command is ignored unless the key register (address 2) holds 16h.
- R11: Reading the status register clears status bits 5..2 after the read. Bit 6 is kept.
- R12: A halt command (0011) during a transfer returns the engine to idle at once (`dma_req` low, strobe high) and sets the end-of-data flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register address: 0 command, 1 status, 2 key |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| dma_req | output | 1 | Byte request to the DMA side |
| dma_ack | input | 1 | DMA acknowledge, completes a request |
| dma_tc | input | 1 | Terminal count, valid with dma_ack |
| dma_wdata | input | 8 | Byte from DMA for sending |
| dma_rdata | output | 8 | Received byte for DMA |
| pd_out | output | 8 | Data pins, output value |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Data pins, input value |
| strobe_n | output | 1 | Strobe control, low active |
| autofd_n | output | 1 | Line-feed control used as receive latch pulse, low active |
| ack_n | input | 1 | Acknowledge from the device, low active |
| busy_n | input | 1 | Busy line; low pauses sending |
| slct | input | 1 | Select status line |
| err_n | input | 1 | Error status line |
| pe | input | 1 | Paper end status line |
| irq | output | 1 | Interrupt request |

## Verification
A four-byte send block is run from a table of byte values, with the terminal count only on the last row. This shows whether each byte reaches the pins in order and whether the engine stops exactly at the flagged byte. A busy-low interval in the middle of the block separates pacing from plain request generation. A single receive byte, paced by acknowledge edges, tells the receive handshake order apart from the send order. Command writes without the key, with an illegal code and with a halt in mid-transfer separate ignored commands from accepted ones. Toggling enabled and disabled status lines tells enable gating apart from read-to-clear behaviour.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd2;
  localparam logic [7:0] KEY_VAL = 8'h16;
  localparam int N_LINES = 4;  // {pe, err_n, slct, ack_n}

  typedef enum logic [2:0] {
    S_IDLE, S_TX_REQ, S_TX_STB, S_RX_WAIT, S_RX_LATCH, S_RX_REQ, S_RX_STB
  } seq_st_t;
endpackage

// File: rtl/ppdma_evt.sv
module ppdma_evt
  import ppdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] line_chg,
  output logic               ack_fall
);
  logic [N_LINES-1:0] prev_q;
  logic               primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= line_in[g];
    end
    assign line_chg[g] = primed_q & (prev_q[g] ^ line_in[g]);
  end

  assign ack_fall = primed_q & prev_q[0] & ~line_in[0];
endmodule

// File: rtl/ppdma_regs.sv
module ppdma_regs
  import ppdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              active,
  input  logic              done,
  input  logic [N_LINES-1:0] chg,
  output logic              cmd_start,
  output logic              cmd_arm,
  output logic              cmd_halt,
  output logic              cmd_dis,
  output logic              irq
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] en_q, en_d, src_q, src_d, src_set;
  logic            eod_q, eod_d;
  logic [DW-1:0]   key_q, key_d;
  logic [3:0]      code;
  logic            cmd_wr, legal, accept, key_ok;

  assign code   = {wdata[7], wdata[6], wdata[1], wdata[0]};
  assign cmd_wr = wr && (addr == A_CMD);
  assign key_ok = (key_q == KEY_VAL);

  always_comb begin
    unique case (code)
      4'b0001, 4'b0010, 4'b0011: legal = 1'b1;
      4'b0101, 4'b1001:          legal = key_ok && !active;
      default:                   legal = 1'b0;
    endcase
  end

  assign accept    = cmd_wr && legal;
  assign cmd_start = accept && (code == 4'b1001);
  assign cmd_arm   = accept && (code == 4'b0101);
  assign cmd_halt  = accept && (code == 4'b0011);
  assign cmd_dis   = accept && (code == 4'b0010);

  // source order: [3] done/ack, [2] slct, [1] err, [0] pe
  assign src_set = {en_q[3] & (done | (chg[0] & eod_q)),
                    en_q[2] & chg[1],
                    en_q[1] & chg[2],
                    en_q[0] & chg[3]};

  always_comb begin
    en_d  = accept ? wdata[5:2] : en_q;
    key_d = (wr && addr == A_KEY) ? wdata : key_q;
    src_d = ((rd && addr == A_STAT) ? '0 : src_q) | src_set;
    eod_d = eod_q;
    if (cmd_dis || cmd_start || cmd_arm) eod_d = 1'b0;
    else if (cmd_halt || done)           eod_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      src_q <= '0;
      eod_q <= 1'b0;
      key_q <= '0;
    end else begin
      en_q  <= en_d;
      src_q <= src_d;
      eod_q <= eod_d;
      key_q <= key_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CMD:   rdata = {2'b00, en_q, 1'b0, active};
      A_STAT:  rdata = {1'b0, eod_q, src_q, 2'b00};
      A_KEY:   rdata = key_q;
      default: rdata = '0;
    endcase
  end

  assign irq = |src_q;
endmodule

// File: rtl/ppdma_seq.sv
module ppdma_seq
  import ppdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_arm,
  input  logic          cmd_halt,
  input  logic          cmd_dis,
  input  logic          ack_n,
  input  logic          busy_n,
  input  logic          ack_fall,
  input  logic          dma_ack,
  input  logic          dma_tc,
  input  logic [DW-1:0] dma_wdata,
  input  logic [DW-1:0] pd_in,
  output logic          dma_req,
  output logic [DW-1:0] dma_rdata,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          active,
  output logic          done
);
  seq_st_t       st_q, st_d;
  logic [DW-1:0] tx_q, rx_q;
  logic          last_q, last_d;
  logic          tx_ld, rx_ld;

  assign dma_req  = ((st_q == S_TX_REQ) && busy_n && ack_n) || (st_q == S_RX_REQ);
  assign strobe_n = !((st_q == S_TX_STB) || (st_q == S_RX_STB));
  assign autofd_n = (st_q != S_RX_LATCH);
  assign pd_oe    = !((st_q == S_RX_WAIT) || (st_q == S_RX_LATCH) ||
                      (st_q == S_RX_REQ)  || (st_q == S_RX_STB));
  assign active   = (st_q != S_IDLE);
  assign pd_out   = tx_q;
  assign dma_rdata = rx_q;

  always_comb begin
    st_d   = st_q;
    last_d = last_q;
    tx_ld  = 1'b0;
    rx_ld  = 1'b0;
    done   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_start)    st_d = S_TX_REQ;
        else if (cmd_arm) st_d = S_RX_WAIT;
      end
      S_TX_REQ: if (dma_req && dma_ack) begin
        tx_ld = 1'b1; last_d = dma_tc; st_d = S_TX_STB;
      end
      S_TX_STB: if (!ack_n) begin
        done = last_q; st_d = last_q ? S_IDLE : S_TX_REQ;
      end
      S_RX_WAIT:  if (ack_fall) st_d = S_RX_LATCH;
      S_RX_LATCH: begin rx_ld = 1'b1; st_d = S_RX_REQ; end
      S_RX_REQ: if (dma_ack) begin
        last_d = dma_tc; st_d = S_RX_STB;
      end
      S_RX_STB: if (ack_n) begin
        done = last_q; st_d = last_q ? S_IDLE : S_RX_WAIT;
      end
      default: st_d = S_IDLE;
    endcase
    if (cmd_dis) begin
      st_d = S_IDLE; done = 1'b0;
    end else if (cmd_halt && active) begin
      st_d = S_IDLE; done = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      last_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
      if (tx_ld) tx_q <= dma_wdata;
      if (rx_ld) rx_q <= pd_in;
    end
  end
endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
  import ppdma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              dma_tc,
  input  logic [DW-1:0]     dma_wdata,
  output logic [DW-1:0]     dma_rdata,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  input  logic [DW-1:0]     pd_in,
  output logic              strobe_n,
  output logic              autofd_n,
  input  logic              ack_n,
  input  logic              busy_n,
  input  logic              slct,
  input  logic              err_n,
  input  logic              pe,
  output logic              irq
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] chg;
  logic               ack_fall, active, done;
  logic               cmd_start, cmd_arm, cmd_halt, cmd_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ppdma_evt u_evt (
    .clk(clk), .rst_n(rst_int_n),
    .line_in({pe, err_n, slct, ack_n}),
    .line_chg(chg), .ack_fall(ack_fall)
  );

  ppdma_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .active(active), .done(done), .chg(chg),
    .cmd_start(cmd_start), .cmd_arm(cmd_arm), .cmd_halt(cmd_halt),
    .cmd_dis(cmd_dis), .irq(irq)
  );

  ppdma_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_start(cmd_start), .cmd_arm(cmd_arm), .cmd_halt(cmd_halt),
    .cmd_dis(cmd_dis), .ack_n(ack_n), .busy_n(busy_n), .ack_fall(ack_fall),
    .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_wdata(dma_wdata), .pd_in(pd_in),
    .dma_req(dma_req), .dma_rdata(dma_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .strobe_n(strobe_n), .autofd_n(autofd_n), .active(active), .done(done)
  );
endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_req,
  input logic          pd_oe,
  input logic          busy_n,
  input logic          ack_n,
  input logic          strobe_n,
  input logic          autofd_n,
  input logic [DW-1:0] pd_out
);
  AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && pd_oe) |=> (strobe_n || $stable(pd_out)));  // R1

  AST_NO_REQ_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !dma_req);  // R2

  AST_TX_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && pd_oe) |-> (busy_n && ack_n));  // R3

  AST_AFD_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !autofd_n |-> !pd_oe);  // R4

  AST_STB_AFD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!autofd_n && !strobe_n));  // R4
endmodule

bind ppdma_engine ppdma_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .pd_oe(pd_oe),
  .busy_n(busy_n), .ack_n(ack_n), .strobe_n(strobe_n),
  .autofd_n(autofd_n), .pd_out(pd_out)
);

// File: tb/sim_ppdma_engine.sv
`timescale 1ns/1ps
module sim_ppdma_engine;
  localparam int DW = 8;
  localparam int NV = 4;
  // {terminal count, byte}
  localparam logic [8:0] VEC [NV] = '{9'h03C, 9'h0A7, 9'h0FF, 9'h181};

  logic clk, rst_n, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, dma_wdata, dma_rdata, pd_out, pd_in;
  logic dma_req, dma_ack, dma_tc, pd_oe, strobe_n, autofd_n;
  logic ack_n, busy_n, slct, err_n, pe, irq;
  int checks = 0, errors = 0;
  logic [DW-1:0] rv;

  ppdma_engine #(.DW(DW)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    dma_ack = 0; dma_tc = 0; dma_wdata = 0; pd_in = 0;
    ack_n = 1; busy_n = 1; slct = 0; err_n = 1; pe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R9 reset strobe_n", {7'b0, strobe_n}, 8'h01);
    chk("R9 reset autofd_n", {7'b0, autofd_n}, 8'h01);
    chk("R9 reset dma_req/irq", {6'b0, dma_req, irq}, 8'h00);
    chk("R9 reset pd_oe", {7'b0, pd_oe}, 8'h01);

    // R10: start without key is ignored
    wreg(2'd0, 8'b1010_0001);
    #1 chk("R10 no key no request", {7'b0, dma_req}, 8'h00);
    rreg(2'd0, rv); chk("R10 cmd reg unchanged", rv, 8'h00);

    wreg(2'd2, 8'h16);
    wreg(2'd0, 8'b1010_0001);  // start send, enable bit 5
    rreg(2'd0, rv); chk("R5 cmd readback", rv, 8'h21);

    for (int i = 0; i < NV; i++) begin
      if (i == 1) begin
        busy_n = 1'b0;
        @(negedge clk); #1 chk("R3 busy holds request", {7'b0, dma_req}, 8'h00);
        busy_n = 1'b1;
      end
      #1 chk("R2 request present", {7'b0, dma_req}, 8'h01);
      dma_ack = 1'b1; dma_wdata = VEC[i][7:0]; dma_tc = VEC[i][8];
      @(negedge clk); dma_ack = 1'b0; dma_tc = 1'b0;
      #1 chk("R1 strobe low", {7'b0, strobe_n}, 8'h00);
      chk("R1 data on pins", pd_out, VEC[i][7:0]);
      @(negedge clk); #1 chk("R1 strobe held", {7'b0, strobe_n}, 8'h00);
      ack_n = 1'b0;
      @(negedge clk); #1 chk("R2 strobe released", {7'b0, strobe_n}, 8'h01);
      chk("R2 no request while ack low", {7'b0, dma_req}, 8'h00);
      ack_n = 1'b1;
    end
    @(negedge clk); #1 chk("R2 idle after last", {7'b0, dma_req}, 8'h00);
    chk("R7 irq on completion", {7'b0, irq}, 8'h01);
    rreg(2'd1, rv); chk("R9 status after send", rv, 8'h60);
    rreg(2'd1, rv); chk("R11 read clears sources", rv, 8'h40);
    #1 chk("R11 irq cleared", {7'b0, irq}, 8'h00);

    // R6: illegal code ignored
    wreg(2'd0, 8'b1101_1101);
    rreg(2'd0, rv); chk("R6 illegal ignored", rv, 8'h20);
    #1 chk("R6 no request", {7'b0, dma_req}, 8'h00);

    // R4 receive one byte
    wreg(2'd0, 8'b0110_0001);
    pd_in = 8'hA5; ack_n = 1'b0;
    @(negedge clk); #1 chk("R4 autofd low", {7'b0, autofd_n}, 8'h00);
    chk("R4 pins released", {7'b0, pd_oe}, 8'h00);
    @(negedge clk); #1 chk("R4 autofd back high", {7'b0, autofd_n}, 8'h01);
    chk("R4 request to dma", {7'b0, dma_req}, 8'h01);
    chk("R4 byte to dma", dma_rdata, 8'hA5);
    dma_ack = 1'b1; dma_tc = 1'b1;
    @(negedge clk); dma_ack = 1'b0; dma_tc = 1'b0;
    #1 chk("R4 strobe low after take", {7'b0, strobe_n}, 8'h00);
    ack_n = 1'b1;
    @(negedge clk); #1 chk("R4 strobe high on ack high", {7'b0, strobe_n}, 8'h01);
    rreg(2'd1, rv); chk("R7 status after receive", rv, 8'h60);
    ack_n = 1'b0;
    @(negedge clk); #1 chk("R7 ack change with eod", {7'b0, irq}, 8'h01);
    ack_n = 1'b1;
    rreg(2'd1, rv); chk("R7 ack source", rv, 8'h60);

    // R12 halt mid-transfer
    wreg(2'd0, 8'b1000_0001);
    rreg(2'd1, rv); chk("R9 eod cleared on start", rv, 8'h00);
    #1 chk("R12 request before halt", {7'b0, dma_req}, 8'h01);
    wreg(2'd0, 8'b0000_0011);
    #1 chk("R12 halted no request", {7'b0, dma_req}, 8'h00);
    rreg(2'd0, rv); chk("R12 idle", rv, 8'h00);
    rreg(2'd1, rv); chk("R12 eod set", rv, 8'h40);

    // R8 status line interrupts
    wreg(2'd0, 8'b0001_1001);
    slct = 1'b1;
    @(negedge clk); #1 chk("R8 slct irq", {7'b0, irq}, 8'h01);
    rreg(2'd1, rv); chk("R8 slct source", rv, 8'h50);
    err_n = 1'b0;
    @(negedge clk);
    rreg(2'd1, rv); chk("R8 err source", rv, 8'h48);
    pe = 1'b1;
    @(negedge clk); #1 chk("R8 pe disabled", {7'b0, irq}, 8'h00);

    wreg(2'd0, 8'b0000_0010);
    rreg(2'd1, rv); chk("R5 disable clears eod", rv, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule